// File: doc/BRIEF.md
# Keyed Configuration Port

This block gives a host a byte-wide path into a chip's configuration space through just two I/O locations: an index port and a data port. The host first writes a register number to the index port, then reads or writes that register through the data port. Before any of this works, the port must be opened by writing a fixed key byte to the index port twice in succession. A separate close byte shuts it again. While closed, the port returns all-ones and ignores data writes.

Inside, register numbers below the bank base address a small global bank. That bank holds a selector naming the current logical device, plus read-only identification bytes. Register numbers at or above the bank base go to the selected device. The enable register at the bank base is kept in the port, one bit per device, and drives a per-device enable output. Every higher register is forwarded to the attached function blocks as a write strobe or read strobe, tagged with the device number and register number. Read data comes back from those blocks on a shared input. A function such as a watchdog timer sits behind device number 7.

Top module: `keyed_cfg_port`

## Requirements
- R1: After the synchronous active-low reset the port is closed, every device enable is 0, the device selector is 0 and no forwarded strobe is active.
- R2: The port opens only when two index-port writes of 0x87 arrive with no other index-port write between them; data-port accesses in between do not disturb the sequence.
- R3: An index-port write of any value other than 0x87 after the first key write returns the sequence to its start, so 0x87, 0x11, 0x87 leaves the port closed.
- R4: An index-port write of 0xAA while open closes the port; reads then return 0xFF and configuration state is kept.
- R5: While the port is closed, reads of either port return 0xFF and data-port writes change no register.
- R6: Register 0x07 is a read/write byte holding the selected logical device number.
- R7: Registers 0x20 and 0x21 return the device ID high then low byte, 0x22 the revision byte, and 0x23 and 0x24 the manufacturer ID high then low byte. Writes to these registers have no effect.
- R8: Register 0x30 stores bit 0 as the enable of the selected device only. That bit drives dev_en[n] for device n, and reads of 0x30 return it in bit 0 with bits 7:1 zero.
- R9: An open data-port write to a register at or above 0x31 pulses fn_wr in that cycle with fn_sel, fn_idx and fn_wdata carrying the device, register and byte. A read there asserts fn_rd and returns fn_rdata.
- R10: When the selector holds a number at or above NUM_LD, bank registers read 0x00, enable writes are dropped and fn_wr stays low.
- R11: Global registers other than 0x07 and 0x20 to 0x24 read 0x00.
- R12: While open, an index-port read returns the last register number written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_sel_data | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_rd |
| fn_wr | output | 1 | Forwarded register write strobe |
| fn_rd | output | 1 | Forwarded register read strobe |
| fn_sel | output | $clog2(NUM_LD) | Device number of the forwarded access |
| fn_idx | output | 8 | Register number of the forwarded access |
| fn_wdata | output | 8 | Byte of the forwarded write |
| fn_rdata | input | 8 | Read byte returned by the function blocks |
| dev_en | output | NUM_LD | Enable bit per logical device |

## Verification
The bench breaks the key sequence with a foreign index byte and shows the port stays closed until a fresh key pair arrives. A design that only counted key bytes would open early. It writes data while closed and later reads the target back after opening. A port that leaked those writes would show the written value instead of the reset value. It sets enables under two selectors and reads a third, which catches an unbanked enable. It then points the selector past the last device, where a design without a range check would alias onto a real device and forward a write.

// File: rtl/cfgp_pkg.sv
// Shared constants and types of the keyed configuration port.
// Assumes byte-wide register numbers and data.
package cfgp_pkg;
    typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;

    localparam logic [7:0] KEY_OPEN     = 8'h87;
    localparam logic [7:0] KEY_CLOSE    = 8'hAA;
    localparam logic [7:0] REG_LDSEL    = 8'h07;
    localparam logic [7:0] REG_DEVID_HI = 8'h20;
    localparam logic [7:0] REG_DEVID_LO = 8'h21;
    localparam logic [7:0] REG_REV      = 8'h22;
    localparam logic [7:0] REG_MFG_HI   = 8'h23;
    localparam logic [7:0] REG_MFG_LO   = 8'h24;
    localparam logic [7:0] REG_ENABLE   = 8'h30;
    localparam logic [7:0] BANK_BASE    = 8'h30;
endpackage

// File: rtl/cfgp_gate.sv
// Key gate: tracks the open/close key sequence on index-port writes and
// holds the index register. Assumes idx_wr is a one-cycle strobe.
module cfgp_gate
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index
);
    key_state_e state;

    // Advance the key sequence and capture register numbers while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_LOCKED;
            index <= 8'h00;
        end else if (idx_wr) begin
            case (state)
                KS_LOCKED: if (wdata == KEY_OPEN) state <= KS_HALF;
                KS_HALF:   state <= (wdata == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   begin
                    if (wdata == KEY_CLOSE) state <= KS_LOCKED;
                    else                    index <= wdata;
                end
                default:   state <= KS_LOCKED;
            endcase
        end
    end

    // Open flag for the rest of the port.
    assign unlocked = (state == KS_OPEN);

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN));
    // R3
    broken_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_HALF && idx_wr && wdata != KEY_OPEN) |=> !unlocked && state == KS_LOCKED);
    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);
endmodule

// File: rtl/cfgp_global.sv
// Global bank: device selector at 0x07 and read-only identification bytes.
// Assumes wr_en is already qualified by the open state and the data port.
module cfgp_global
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID = 16'h5A31,
    parameter logic [7:0]  DEV_REV = 8'h04,
    parameter logic [15:0] MFG_ID = 16'h2C17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ld_sel,
    output logic [7:0] rd_data
);
    // Selector register, the only writable global.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ld_sel <= 8'h00;
        else if (wr_en && idx == REG_LDSEL)  ld_sel <= wdata;
    end

    // Read decode of the global bank.
    always_comb begin
        case (idx)
            REG_LDSEL:    rd_data = ld_sel;
            REG_DEVID_HI: rd_data = DEV_ID[15:8];
            REG_DEVID_LO: rd_data = DEV_ID[7:0];
            REG_REV:      rd_data = DEV_REV;
            REG_MFG_HI:   rd_data = MFG_ID[15:8];
            REG_MFG_LO:   rd_data = MFG_ID[7:0];
            default:      rd_data = 8'h00;
        endcase
    end

    // R6
    ldsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ld_sel));
endmodule

// File: rtl/cfgp_enbank.sv
// Per-device enable bits at bank register 0x30. Assumes wr_en is already
// qualified by the open state and the data port; out-of-range selectors
// reach no device.
module cfgp_enbank
    import cfgp_pkg::*;
#(
    parameter int NUM_LD = 8,
    localparam int LDW = $clog2(NUM_LD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              wr_en,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    input  logic [7:0]        ld_sel,
    output logic              sel_ok,
    output logic [NUM_LD-1:0] dev_en,
    output logic [7:0]        rd_data
);
    localparam logic [8:0] LD_LIMIT = 9'(NUM_LD);

    logic [LDW-1:0] ld_idx;
    logic           en_hit;

    // Range check and write qualification.
    assign sel_ok = ({1'b0, ld_sel} < LD_LIMIT);
    assign ld_idx = ld_sel[LDW-1:0];
    assign en_hit = wr_en && sel_ok && (idx == REG_ENABLE);

    for (genvar g = 0; g < NUM_LD; g++) begin : g_en
        // Enable flop of device g.
        always_ff @(posedge clk) begin
            if (!rst_n)                                dev_en[g] <= 1'b0;
            else if (en_hit && ld_idx == LDW'(g))      dev_en[g] <= wdata[0];
        end
    end

    // Read of the selected device's enable.
    assign rd_data = {7'b0, sel_ok & dev_en[ld_idx]};

    // R5
    locked_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(dev_en));
    // R10
    badsel_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> $stable(dev_en));
endmodule

// File: rtl/keyed_cfg_port.sv
// Keyed index/data configuration port. Routes data-port accesses to the
// global bank or the selected device bank and forwards device registers
// above the enable register to attached function blocks.
// Assumes bus_wr and bus_rd are one-cycle strobes, never both high.
module keyed_cfg_port
    import cfgp_pkg::*;
#(
    parameter int          NUM_LD  = 8,
    parameter logic [15:0] DEV_ID  = 16'h5A31,
    parameter logic [7:0]  DEV_REV = 8'h04,
    parameter logic [15:0] MFG_ID  = 16'h2C17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic                      bus_sel_data,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic                      fn_wr,
    output logic                      fn_rd,
    output logic [$clog2(NUM_LD)-1:0] fn_sel,
    output logic [7:0]                fn_idx,
    output logic [7:0]                fn_wdata,
    input  logic [7:0]                fn_rdata,
    output logic [NUM_LD-1:0]         dev_en
);
    localparam int LDW = $clog2(NUM_LD);

    logic       unlocked, sel_ok, data_wr, in_bank, fwd_reg;
    logic [7:0] index, ld_sel, glob_rd, en_rd;

    // Access qualification.
    assign data_wr = bus_wr && bus_sel_data && unlocked;
    assign in_bank = (index >= BANK_BASE);
    assign fwd_reg = in_bank && (index != REG_ENABLE) && sel_ok;

    cfgp_gate u_gate (
        .clk(clk), .rst_n(rst_n), .idx_wr(bus_wr && !bus_sel_data),
        .wdata(bus_wdata), .unlocked(unlocked), .index(index)
    );

    cfgp_global #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFG_ID(MFG_ID)) u_glob (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr && !in_bank),
        .idx(index), .wdata(bus_wdata), .ld_sel(ld_sel), .rd_data(glob_rd)
    );

    cfgp_enbank #(.NUM_LD(NUM_LD)) u_en (
        .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .wr_en(data_wr),
        .idx(index), .wdata(bus_wdata), .ld_sel(ld_sel), .sel_ok(sel_ok),
        .dev_en(dev_en), .rd_data(en_rd)
    );

    // Forwarded access to the attached function blocks.
    assign fn_wr    = data_wr && fwd_reg;
    assign fn_rd    = bus_rd && bus_sel_data && unlocked && fwd_reg;
    assign fn_sel   = ld_sel[LDW-1:0];
    assign fn_idx   = index;
    assign fn_wdata = bus_wdata;

    // Read data selection across port, bank and lock state.
    always_comb begin
        if (!unlocked)                bus_rdata = 8'hFF;
        else if (!bus_sel_data)       bus_rdata = index;
        else if (!in_bank)            bus_rdata = glob_rd;
        else if (index == REG_ENABLE) bus_rdata = en_rd;
        else if (sel_ok)              bus_rdata = fn_rdata;
        else                          bus_rdata = 8'h00;
    end

    // R9
    fn_wr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fn_wr |-> unlocked && bus_sel_data);
    // R10
    fn_sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_wr || fn_rd) |-> ({1'b0, ld_sel} < 9'(NUM_LD)));
    // R1
    reset_closed_chk: assert property (@(posedge clk)
        !rst_n |=> !unlocked && dev_en == '0);
endmodule

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata, fn_idx, fn_wdata;
    logic [7:0] fn_rdata = 8'h5A;
    logic       fn_wr, fn_rd;
    logic [2:0] fn_sel;
    logic [7:0] dev_en;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       l_wr;
    logic [2:0] l_sel;
    logic [7:0] l_idx, l_dat;

    always #10 clk = ~clk;

    keyed_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fn_wr(fn_wr), .fn_rd(fn_rd), .fn_sel(fn_sel), .fn_idx(fn_idx),
        .fn_wdata(fn_wdata), .fn_rdata(fn_rdata), .dev_en(dev_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one write access; captures forwarded-write outputs mid-cycle.
    task automatic do_wr(input bit data_port, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel_data = data_port; bus_wdata = d;
        #5;
        l_wr = fn_wr; l_sel = fn_sel; l_idx = fn_idx; l_dat = fn_wdata;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: one read access; the expected byte goes to the scoreboard.
    task automatic do_rd(input bit data_port, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel_data = data_port;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
        do_wr(1'b0, r);
        do_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] r, input logic [7:0] exp, input string tag);
        do_wr(1'b0, r);
        do_rd(1'b1, exp, tag);
    endtask

    // Monitor: compares each read against the scoreboard mid-cycle.
    always begin
        @(negedge clk);
        #5;
        if (bus_rd) begin
            if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", bus_rdata, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(dev_en == 8'h00, "R1 dev_en after reset", dev_en, 0);
        check(fn_wr == 1'b0 && fn_rd == 1'b0, "R1 strobes idle", {fn_wr, fn_rd}, 0);
        do_rd(1'b1, 8'hFF, "R1 closed data read");
        do_rd(1'b0, 8'hFF, "R5 closed index read");
        // Closed data write must not reach the selector (R5)
        do_wr(1'b0, 8'h07);
        do_wr(1'b1, 8'h03);
        // R3: broken sequence keeps the port closed
        do_wr(1'b0, 8'h87);
        do_wr(1'b0, 8'h11);
        do_wr(1'b0, 8'h87);
        do_rd(1'b1, 8'hFF, "R3 broken key stays closed");
        // R2: the second consecutive key opens (data read above did not disturb)
        do_wr(1'b0, 8'h87);
        do_wr(1'b0, 8'h07);
        do_rd(1'b0, 8'h07, "R12 index readback");
        do_rd(1'b1, 8'h00, "R5 closed write ignored");
        do_wr(1'b1, 8'h05);
        do_rd(1'b1, 8'h05, "R6 selector readback");
        reg_rd(8'h20, 8'h5A, "R7 devid hi");
        reg_rd(8'h21, 8'h31, "R7 devid lo");
        reg_rd(8'h22, 8'h04, "R7 revision");
        reg_rd(8'h23, 8'h2C, "R7 mfg hi");
        reg_rd(8'h24, 8'h17, "R7 mfg lo");
        reg_wr(8'h20, 8'h00);
        reg_rd(8'h20, 8'h5A, "R7 id write ignored");
        reg_rd(8'h2B, 8'h00, "R11 unassigned global");
        // R8: banked enables
        reg_wr(8'h30, 8'hFF);
        check(dev_en == 8'h20, "R8 enable dev5", dev_en, 8'h20);
        reg_rd(8'h30, 8'h01, "R8 enable readback");
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h30, 8'h01);
        check(dev_en == 8'hA0, "R8 enable dev7", dev_en, 8'hA0);
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h30, 8'h00, "R8 dev2 enable clear");
        // R9: forwarded access on device 7
        reg_wr(8'h07, 8'h07);
        reg_wr(8'hF5, 8'h3C);
        check(l_wr == 1'b1 && l_sel == 3'd7 && l_idx == 8'hF5 && l_dat == 8'h3C,
              "R9 forwarded write", {l_wr, l_sel, l_idx, l_dat}, {1'b1, 3'd7, 8'hF5, 8'h3C});
        fn_rdata = 8'hC3;
        reg_rd(8'hF5, 8'hC3, "R9 forwarded read");
        // R10: selector beyond the last device
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h00);
        check(dev_en == 8'hA0, "R10 enables unchanged", dev_en, 8'hA0);
        reg_rd(8'h30, 8'h00, "R10 enable read zero");
        reg_wr(8'hF6, 8'h11);
        check(l_wr == 1'b0, "R10 no forwarded write", l_wr, 0);
        reg_rd(8'hF6, 8'h00, "R10 bank read zero");
        // R4: close key
        do_wr(1'b0, 8'hAA);
        do_rd(1'b1, 8'hFF, "R4 data read after close");
        do_rd(1'b0, 8'hFF, "R4 index read after close");
        check(dev_en == 8'hA0, "R4 state kept", dev_en, 8'hA0);
        do_wr(1'b0, 8'h87);
        do_wr(1'b0, 8'h87);
        reg_rd(8'h07, 8'h09, "R4 selector kept across close");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule